// File: doc/BRIEF.md
# Ring Melody Tone Generator

This block drives a buzzer with a square wave at one of eight fixed melody pitches while a telephone rings. A 3-bit tone code is written ahead of time and held in the block. A separate start strobe begins ringing with that code. A stop strobe ends ringing, but only after the square period in progress has finished, so the buzzer never sees a cut-off pulse. Each half-period is counted in ticks of a 1.79 MHz reference clock enable. The tick count is the rounded quotient of the reference rate by twice the tone frequency.

The block also holds a 2-bit ring volume step and presents it as a level code to an external amplifier. When the internal tone is stopped and ring mode is on, an active-low external melody input drives the buzzer output directly. This lets other melodies be produced outside the block.

Top module: `ring_melody_gen`

## Requirements
- R1: After reset, `buzzOut` is 0, `busy` is 0 and `levelOut` is 3 (level 4). The stored tone code is 7, so a start with no prior write rings at 1312 Hz.
- R2: The tone code selects a frequency as follows: 0=822 Hz, 1=744 Hz, 2=1005 Hz, 3=909 Hz, 4=1187 Hz, 5=1074 Hz, 6=1451 Hz, 7=1312 Hz. Each high half and each low half lasts round(1790000 / (2·f)) reference ticks.
- R3: Writing a tone code with `toneWr` while idle only stores it. `buzzOut` and `busy` stay 0 until `ringStart`.
- R4: `ringStart` while idle sets `busy` and drives `buzzOut` high from the next cycle. The first high half has full length.
- R5: After `ringStop`, the current period (high half then low half) completes in full. `busy` and `buzzOut` then fall together at the end of the low half, and `buzzOut` stays 0 afterwards. `ringStop` while idle has no effect.
- R6: `ringStart` while ringing cancels any pending stop. The currently stored tone code takes over at the next period boundary, and the period in progress keeps its old pitch.
- R7: `levelWr` loads `levelCode` into `levelOut` on the next cycle (0 = level 1 minimum, 3 = level 4 maximum). Without `levelWr`, `levelOut` holds its value, and level writes never start ringing.
- R8: While idle with `ringMode` = 1, `buzzOut` equals the inverse of `melodyN`. While idle with `ringMode` = 0, `buzzOut` is 0. While ringing, `melodyN` has no effect.
- R9: The half-period counter advances only in cycles where `refEn` is 1. With `refEn` every other cycle, each low half lasts exactly twice as many clock cycles as its tick count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| refEn | input | 1 | 1.79 MHz reference tick enable |
| ringMode | input | 1 | Ring mode active; gates the external melody path |
| toneWr | input | 1 | Store `toneCode` |
| toneCode | input | 3 | Melody tone selector |
| ringStart | input | 1 | Start (or re-arm) ringing strobe |
| ringStop | input | 1 | Stop ringing at the end of the current period |
| levelWr | input | 1 | Store `levelCode` |
| levelCode | input | 2 | Volume step, 0 = minimum, 3 = maximum |
| melodyN | input | 1 | Active-low external melody input |
| buzzOut | output | 1 | Buzzer square-wave drive |
| levelOut | output | 2 | Current volume step |
| busy | output | 1 | Internal tone running |

## Verification
The hardest case to reach from the ports is a re-start that lands while a stop is already pending. The new code must then wait for the period boundary, and the stop must be cancelled. The bench places both strobes and a tone write inside one long high half of the slowest-but-one pitch. It then measures the remaining high half, the full low half and the next period at the new pitch, and checks that `busy` stays set throughout. A sweep over all eight codes measures both halves of every pitch against a quotient computed in the bench. A slowed `refEn` run shows that the counter advances only on reference ticks.

// File: rtl/melody_pkg.sv
package melody_pkg;
  localparam int CODE_W    = 3;
  localparam int LVL_W     = 2;
  localparam int NUM_TONES = 1 << CODE_W;

  typedef struct packed {
    logic launch;  // begin ringing from idle
    logic adopt;   // switch to stored code at period boundary
    logic halt;    // end ringing at period boundary
  } melStrobe_t;

  function automatic int toneHz(input int idx);
    case (idx)
      0:       return 822;
      1:       return 744;
      2:       return 1005;
      3:       return 909;
      4:       return 1187;
      5:       return 1074;
      6:       return 1451;
      default: return 1312;
    endcase
  endfunction

  function automatic int halfTicks(input int refHz, input int idx);
    return (refHz + toneHz(idx)) / (2 * toneHz(idx));
  endfunction

  function automatic int maxHalf(input int refHz);
    int m;
    m = 0;
    for (int i = 0; i < NUM_TONES; i++)
      if (halfTicks(refHz, i) > m) m = halfTicks(refHz, i);
    return m;
  endfunction
endpackage

// File: rtl/melody_ctrl.sv
module melody_ctrl
  import melody_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             ringStart,
  input  logic             ringStop,
  input  logic             levelWr,
  input  logic [LVL_W-1:0] levelCode,
  input  logic             periodEnd,
  output melStrobe_t       strobe,
  output logic             busy,
  output logic [LVL_W-1:0] levelOut
);
  logic stopPend;
  logic adoptPend;
  logic stopEff;
  logic adoptEff;

  // a start in the same cycle overrides any stop request
  assign stopEff  = (stopPend || ringStop) && !ringStart;
  assign adoptEff = adoptPend || ringStart;

  always_comb begin
    strobe = '0;
    if (ringStart && !busy) begin
      strobe.launch = 1'b1;
    end else if (busy && periodEnd) begin
      if (stopEff)       strobe.halt  = 1'b1;
      else if (adoptEff) strobe.adopt = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy      <= 1'b0;
      stopPend  <= 1'b0;
      adoptPend <= 1'b0;
    end else if (strobe.launch) begin
      busy      <= 1'b1;
      stopPend  <= 1'b0;
      adoptPend <= 1'b0;
    end else if (strobe.halt) begin
      busy      <= 1'b0;
      stopPend  <= 1'b0;
      adoptPend <= 1'b0;
    end else if (busy) begin
      if (ringStart) begin
        stopPend  <= 1'b0;
        adoptPend <= !periodEnd;
      end else begin
        if (ringStop)  stopPend  <= 1'b1;
        if (periodEnd) adoptPend <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)        levelOut <= '1;
    else if (levelWr) levelOut <= levelCode;
  end
endmodule

// File: rtl/melody_dp.sv
module melody_dp
  import melody_pkg::*;
#(
  parameter int REF_HZ = 1790000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              refEn,
  input  logic              running,
  input  logic              toneWr,
  input  logic [CODE_W-1:0] toneCode,
  input  melStrobe_t        strobe,
  output logic              periodEnd,
  output logic              phase
);
  localparam int CNT_W = $clog2(maxHalf(REF_HZ) + 1);

  logic [CNT_W-1:0]  divTab [NUM_TONES];
  logic [CODE_W-1:0] storedCode;
  logic [CODE_W-1:0] activeCode;
  logic [CNT_W-1:0]  cnt;
  logic              halfEnd;

  for (genvar g = 0; g < NUM_TONES; g++) begin : g_div
    assign divTab[g] = CNT_W'(halfTicks(REF_HZ, g) - 1);
  end

  assign halfEnd   = running && refEn && (cnt == '0);
  assign periodEnd = halfEnd && !phase;

  always_ff @(posedge clk) begin
    if (!rstN)       storedCode <= '1;
    else if (toneWr) storedCode <= toneCode;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      activeCode <= '1;
      cnt        <= '0;
      phase      <= 1'b0;
    end else if (strobe.launch) begin
      activeCode <= storedCode;
      cnt        <= divTab[storedCode];
      phase      <= 1'b1;
    end else if (strobe.halt) begin
      cnt   <= '0;
      phase <= 1'b0;
    end else if (halfEnd) begin
      phase <= !phase;
      if (strobe.adopt) begin
        activeCode <= storedCode;
        cnt        <= divTab[storedCode];
      end else begin
        cnt <= divTab[activeCode];
      end
    end else if (running && refEn) begin
      cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/ring_melody_gen.sv
module ring_melody_gen
  import melody_pkg::*;
#(
  parameter int REF_HZ = 1790000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              refEn,
  input  logic              ringMode,
  input  logic              toneWr,
  input  logic [CODE_W-1:0] toneCode,
  input  logic              ringStart,
  input  logic              ringStop,
  input  logic              levelWr,
  input  logic [LVL_W-1:0]  levelCode,
  input  logic              melodyN,
  output logic              buzzOut,
  output logic [LVL_W-1:0]  levelOut,
  output logic              busy
);
  melStrobe_t strobe;
  logic       periodEnd;
  logic       phase;

  melody_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .ringStart (ringStart),
    .ringStop  (ringStop),
    .levelWr   (levelWr),
    .levelCode (levelCode),
    .periodEnd (periodEnd),
    .strobe    (strobe),
    .busy      (busy),
    .levelOut  (levelOut)
  );

  melody_dp #(.REF_HZ(REF_HZ)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .refEn     (refEn),
    .running   (busy),
    .toneWr    (toneWr),
    .toneCode  (toneCode),
    .strobe    (strobe),
    .periodEnd (periodEnd),
    .phase     (phase)
  );

  assign buzzOut = busy ? phase : (ringMode && !melodyN);
endmodule

// File: rtl/ring_melody_gen_chk.sv
module ring_melody_gen_chk
  import melody_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             refEn,
  input logic             ringMode,
  input logic             ringStart,
  input logic             levelWr,
  input logic [LVL_W-1:0] levelCode,
  input logic             melodyN,
  input logic             buzzOut,
  input logic [LVL_W-1:0] levelOut,
  input logic             busy
);
  p_start_high_r4: assert property (@(posedge clk) disable iff (!rstN)
    (ringStart && !busy) |=> (busy && buzzOut));

  p_end_low_r5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> !$past(buzzOut));

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !ringMode) |-> !buzzOut);

  p_ext_melody_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && ringMode) |-> (buzzOut == !melodyN));

  p_level_load_r7: assert property (@(posedge clk) disable iff (!rstN)
    levelWr |=> (levelOut == $past(levelCode)));

  p_tick_gate_r9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !refEn) |=> (busy && $stable(buzzOut)));
endmodule

bind ring_melody_gen ring_melody_gen_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .refEn     (refEn),
  .ringMode  (ringMode),
  .ringStart (ringStart),
  .levelWr   (levelWr),
  .levelCode (levelCode),
  .melodyN   (melodyN),
  .buzzOut   (buzzOut),
  .levelOut  (levelOut),
  .busy      (busy)
);

// File: tb/sim_ring_melody_gen.sv
module sim_ring_melody_gen;
  localparam int CLK_PERIOD = 10;
  localparam int REF = 1790000;

  logic       clk = 1'b0;
  logic       rstN;
  logic       refEn;
  logic       slowRef;
  logic       ringMode;
  logic       toneWr;
  logic [2:0] toneCode;
  logic       ringStart;
  logic       ringStop;
  logic       levelWr;
  logic [1:0] levelCode;
  logic       melodyN;
  logic       buzzOut;
  logic [1:0] levelOut;
  logic       busy;

  int nTests = 0;
  int nFail  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  ring_melody_gen #(.REF_HZ(REF)) u0 (
    .clk(clk), .rstN(rstN), .refEn(refEn), .ringMode(ringMode),
    .toneWr(toneWr), .toneCode(toneCode), .ringStart(ringStart),
    .ringStop(ringStop), .levelWr(levelWr), .levelCode(levelCode),
    .melodyN(melodyN), .buzzOut(buzzOut), .levelOut(levelOut), .busy(busy)
  );

  always @(negedge clk) refEn <= slowRef ? !refEn : 1'b1;

  function automatic int freqOf(input int c);
    int f[8] = '{822, 744, 1005, 909, 1187, 1074, 1451, 1312};
    return f[c];
  endfunction

  function automatic int expHalf(input int c);
    return (REF + freqOf(c)) / (2 * freqOf(c));
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic countLevel(input logic v, output int n);
    n = 0;
    while (buzzOut == v && busy && n < 20000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic writeTone(input int c);
    toneWr = 1'b1; toneCode = 3'(c);
    @(negedge clk);
    toneWr = 1'b0;
  endtask

  task automatic startRing(input string req);
    ringStart = 1'b1;
    @(negedge clk);
    ringStart = 1'b0;
    check(buzzOut && busy, req, {30'd0, busy, buzzOut}, 3);
  endtask

  task automatic measurePeriod(input int exp, input string req);
    int n;
    countLevel(1'b1, n);
    check(n == exp, req, n, exp);
    countLevel(1'b0, n);
    check(n == exp, req, n, exp);
  endtask

  task automatic stopRing(input int exp);
    int n;
    ringStop = 1'b1;
    countLevel(1'b1, n);
    ringStop = 1'b0;
    check(n == exp, "R5 high half completes", n, exp);
    countLevel(1'b0, n);
    check(n == exp, "R5 low half completes", n, exp);
    check(!busy && !buzzOut, "R5 idle after period", {30'd0, busy, buzzOut}, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    int n;
    int bad;
    rstN = 1'b0; slowRef = 1'b0; refEn = 1'b1; ringMode = 1'b0;
    toneWr = 1'b0; toneCode = '0; ringStart = 1'b0; ringStop = 1'b0;
    levelWr = 1'b0; levelCode = '0; melodyN = 1'b1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state and default tone
    check(!buzzOut && !busy, "R1 reset idle", {30'd0, busy, buzzOut}, 0);
    check(levelOut == 2'd3, "R1 reset level", levelOut, 3);
    startRing("R1 start default");
    measurePeriod(expHalf(7), "R1 default tone 1312Hz");
    stopRing(expHalf(7));

    // R5 stays low after stop; stop while idle has no effect
    bad = 0;
    ringStop = 1'b1;
    repeat (3000) begin
      @(negedge clk);
      if (buzzOut || busy) bad++;
    end
    ringStop = 1'b0;
    check(bad == 0, "R5 idle holds low, stop ignored", bad, 0);
    startRing("R5 start after idle stop");
    measurePeriod(expHalf(7), "R5 no stale stop");
    measurePeriod(expHalf(7), "R5 no stale stop second period");
    stopRing(expHalf(7));

    // R2 / R3 sweep of all tone codes
    for (int c = 0; c < 8; c++) begin
      writeTone(c);
      bad = 0;
      repeat (20) begin
        @(negedge clk);
        if (buzzOut || busy) bad++;
      end
      check(bad == 0, "R3 write alone does not ring", bad, 0);
      startRing("R4 start");
      measurePeriod(expHalf(c), "R2 half period for code");
      stopRing(expHalf(c));
    end

    // R6 restart during pending stop: new code at boundary
    writeTone(0);
    startRing("R6 start");
    ringStop = 1'b1;
    @(negedge clk);
    ringStop = 1'b0; toneWr = 1'b1; toneCode = 3'd6;
    @(negedge clk);
    toneWr = 1'b0; ringStart = 1'b1;
    @(negedge clk);
    ringStart = 1'b0;
    countLevel(1'b1, n);
    check(n == expHalf(0) - 3, "R6 current high keeps old pitch", n, expHalf(0) - 3);
    countLevel(1'b0, n);
    check(n == expHalf(0), "R6 current low keeps old pitch", n, expHalf(0));
    check(busy == 1'b1, "R6 stop cancelled", busy, 1);
    measurePeriod(expHalf(6), "R6 new pitch after boundary");
    stopRing(expHalf(6));

    // R7 level writes
    for (int l = 0; l < 4; l++) begin
      levelWr = 1'b1; levelCode = 2'(l);
      @(negedge clk);
      levelWr = 1'b0; levelCode = 2'(3 - l);
      @(negedge clk);
      check(levelOut == 2'(l), "R7 level load and hold", levelOut, l);
      check(!busy, "R7 level write does not ring", busy, 0);
    end

    // R8 external melody path
    ringMode = 1'b1; melodyN = 1'b0;
    @(negedge clk);
    check(buzzOut == 1'b1, "R8 melody low drives high", buzzOut, 1);
    melodyN = 1'b1;
    @(negedge clk);
    check(buzzOut == 1'b0, "R8 melody high drives low", buzzOut, 0);
    ringMode = 1'b0; melodyN = 1'b0;
    @(negedge clk);
    check(buzzOut == 1'b0, "R8 no ring mode quiet", buzzOut, 0);
    ringMode = 1'b1;
    writeTone(7);
    startRing("R8 start");
    measurePeriod(expHalf(7), "R8 melody ignored while ringing");
    melodyN = 1'b1;
    stopRing(expHalf(7));
    ringMode = 1'b0;

    // R9 reference tick gating
    slowRef = 1'b1;
    repeat (2) @(negedge clk);
    startRing("R9 start");
    countLevel(1'b1, n);
    check(n == 2 * expHalf(7) || n == 2 * expHalf(7) - 1, "R9 high half slowed", n, 2 * expHalf(7));
    countLevel(1'b0, n);
    check(n == 2 * expHalf(7), "R9 low half slowed", n, 2 * expHalf(7));
    ringStop = 1'b1;
    n = 0;
    while (busy && n < 20000) begin
      n++;
      @(negedge clk);
    end
    ringStop = 1'b0;
    check(!busy && !buzzOut, "R9 stop reaches idle", {30'd0, busy, buzzOut}, 0);
    slowRef = 1'b0;

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule